// File: doc/BRIEF.md
# BCD Real-Time Clock Counter Core

This block keeps calendar time as a set of packed BCD bytes: seconds, minutes, hours, day of month, month, day of week and a two-digit year. A clock-enable input that pulses at 32.768 kHz is divided down to one advance per second. Each advance ripples through the chain, and each field rolls over at its own limit. The hours byte can count in a 24-hour form or in a 12-hour form with an afternoon flag. A halt flag in the seconds byte freezes the whole chain.

A serial or bus front end reaches the time through a parallel byte port. A write lands in the live counter at once. A read is two steps. A latch strobe first copies every live counter into a holding bank. The address then selects a byte from that bank. All bytes read after one strobe therefore belong to the same instant, even if a rollover happens while they are being fetched.

Top module: `rtc_bcd_core`

## Requirements
- R1: The seconds field advances once for every DIV cycles in which tick_i is high, and cycles with tick_i low do not move the divider. DIV defaults to 32768.
- R2: Seconds (address 0, bits 6:0) and minutes (address 1) count BCD 00 to 59. A wrap of seconds advances minutes, and a wrap of minutes advances hours.
- R3: When hours bit 7 is 0 (24-hour form), bits 5:0 count BCD 00 to 23, so bit 5 is set for 20 to 23. The step from 23 to 00 advances the day.
- R4: When hours bit 7 is 1 (12-hour form), bits 4:0 run 12, 01, 02 up to 11 and back to 12. Bit 5 is the PM flag (1 = PM) and toggles on the step from 11 to 12. The step from 11 PM to 12 AM advances the day.
- R5: The day of month (address 3) wraps to 01 after the last day of the month held at address 4. April, June, September and November have 30 days. February has 29 days when the BCD year at address 6 is divisible by 4, and 28 otherwise. The other months have 31 days. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: The day of week (address 5, bits 2:0) steps on each day change and wraps from 7 to 1.
- R7: While bit 7 of the seconds byte is 1, no field changes except by a write, and the flag reads back as 1. Writing it back to 0 resumes counting.
- R8: A write to the seconds byte clears the sub-second divider, so the next advance comes a full DIV enabled ticks after the write.
- R9: A high rd_latch_i copies all live fields into the holding bank at the clock edge. reg_rdata_o shows the holding byte selected by reg_addr_i, and it does not change until the next latch.
- R10: Bits with no function read back as 0: hours bit 6, day-of-month bits 7:6, month bits 7:5, day-of-week bits 7:3, minutes bit 7. Address 7 reads 0x00.
- R11: After reset the fields read 00 seconds (running), 00 minutes, 00 hours in 24-hour form, day 01, month 01, weekday 1, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz clock enable |
| rd_latch_i | input | 1 | Copies the live fields into the holding bank |
| reg_wr_i | input | 1 | Write strobe for the addressed field |
| reg_addr_i | input | 3 | Field address (0 sec, 1 min, 2 hour, 3 day, 4 month, 5 weekday, 6 year) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Holding-bank byte at reg_addr_i |

## Verification
Directed starting times sit on each carry boundary. These cover 23:59:59 on the last day of a year, the 11 to 12 steps in both halves of the 12-hour day, February in leap and common years, and 30-day months. A mismatch there points to one specific wrap or flag rule. Random starting times near the end of a minute, hour and month are advanced by several seconds, which checks that carries chain correctly across mode and month combinations. Separate patterns probe the prescaler: partial ticks before a seconds write show whether the divider was cleared, idle cycles show whether ticks are gated, and a halt window shows that time is frozen. Latching before a rollover and reading after it separates the holding bank from the live counters.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NREG = 7;
  localparam int AW = 3;

  localparam logic [AW-1:0] ADR_SEC   = 3'd0;
  localparam logic [AW-1:0] ADR_MIN   = 3'd1;
  localparam logic [AW-1:0] ADR_HOUR  = 3'd2;
  localparam logic [AW-1:0] ADR_DATE  = 3'd3;
  localparam logic [AW-1:0] ADR_MONTH = 3'd4;
  localparam logic [AW-1:0] ADR_DOW   = 3'd5;
  localparam logic [AW-1:0] ADR_YEAR  = 3'd6;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'h9) return {v[7:4] + 4'd1, 4'h0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic leap_year(input logic [7:0] y);
    if (!y[4]) return (y[3:0] == 4'h0) || (y[3:0] == 4'h4) || (y[3:0] == 4'h8);
    else       return (y[3:0] == 4'h2) || (y[3:0] == 4'h6);
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] m, input logic leap);
    case (m)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] field_mask(input logic [AW-1:0] a);
    case (a)
      ADR_SEC:   return 8'hFF;
      ADR_MIN:   return 8'h7F;
      ADR_HOUR:  return 8'hBF;
      ADR_DATE:  return 8'h3F;
      ADR_MONTH: return 8'h1F;
      ADR_DOW:   return 8'h07;
      ADR_YEAR:  return 8'hFF;
      default:   return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768,
  localparam int CW = $clog2(DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          run_i,
  input  logic          clr_i,
  output logic          pulse_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (tick_i && run_i)    cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
  end

  assign pulse_o = tick_i && run_i && !clr_i && (cnt_q == LAST);
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/rtc_clock_chain.sv
module rtc_clock_chain
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pulse_i,
  input  logic [2:0] wr_i,     // sec, min, hour
  input  logic [7:0] wdata_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_o
);
  logic [7:0] sec_q, min_q, hour_q;
  logic [7:0] hour_nx;
  logic       hour_carry;
  logic       sec_wrap, min_wrap, min_adv, hour_adv;

  assign sec_wrap = (sec_q[6:0] == 7'h59);
  assign min_wrap = (min_q[6:0] == 7'h59);
  assign min_adv  = pulse_i && sec_wrap;
  assign hour_adv = min_adv && min_wrap;

  always_comb begin
    hour_carry = 1'b0;
    if (hour_q[7]) begin
      if (hour_q[4:0] == 5'h11) begin
        hour_nx    = {2'b10, ~hour_q[5], 5'h12};
        hour_carry = hour_q[5];
      end else if (hour_q[4:0] == 5'h12) begin
        hour_nx = {2'b10, hour_q[5], 5'h01};
      end else begin
        hour_nx = bcd_inc({3'b000, hour_q[4:0]}) | {hour_q[7:5], 5'b0};
      end
    end else if (hour_q[5:0] == 6'h23) begin
      hour_nx    = 8'h00;
      hour_carry = 1'b1;
    end else begin
      hour_nx = bcd_inc(hour_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      if (wr_i[0])      sec_q <= wdata_i;
      else if (pulse_i) sec_q <= sec_wrap ? {sec_q[7], 7'h00}
                                          : (bcd_inc({1'b0, sec_q[6:0]}) | {sec_q[7], 7'b0});
      if (wr_i[1])      min_q <= wdata_i;
      else if (min_adv) min_q <= min_wrap ? 8'h00 : bcd_inc(min_q);
      if (wr_i[2])       hour_q <= wdata_i;
      else if (hour_adv) hour_q <= hour_nx;
    end
  end

  assign sec_o  = sec_q;
  assign min_o  = min_q;
  assign hour_o = hour_q;
  assign day_o  = hour_adv && hour_carry;
endmodule

// File: rtl/rtc_calendar_chain.sv
module rtc_calendar_chain
  import rtc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       day_i,
  input  logic [3:0] wr_i,     // date, month, dow, year
  input  logic [7:0] wdata_i,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] dow_o,
  output logic [7:0] year_o
);
  logic [7:0] date_q, month_q, year_q;
  logic [2:0] dow_q;
  logic       date_wrap, month_adv, month_wrap, year_adv;

  assign date_wrap  = (date_q == month_days(month_q, leap_year(year_q)));
  assign month_adv  = day_i && date_wrap;
  assign month_wrap = (month_q == 8'h12);
  assign year_adv   = month_adv && month_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      date_q  <= 8'h01;
      month_q <= 8'h01;
      dow_q   <= 3'd1;
      year_q  <= 8'h00;
    end else begin
      if (wr_i[0])    date_q <= wdata_i;
      else if (day_i) date_q <= date_wrap ? 8'h01 : bcd_inc(date_q);
      if (wr_i[1])        month_q <= wdata_i;
      else if (month_adv) month_q <= month_wrap ? 8'h01 : bcd_inc(month_q);
      if (wr_i[2])    dow_q <= wdata_i[2:0];
      else if (day_i) dow_q <= (dow_q == 3'd7) ? 3'd1 : dow_q + 3'd1;
      if (wr_i[3])       year_q <= wdata_i;
      else if (year_adv) year_q <= (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    end
  end

  assign date_o  = date_q;
  assign month_o = month_q;
  assign dow_o   = {5'b0, dow_q};
  assign year_o  = year_q;
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int DIV = 32768,
  localparam int CW = $clog2(DIV)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rd_latch_i,
  input  logic          reg_wr_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o
);
  logic [NREG-1:0]      wr_sel;
  logic [7:0]           wdata_m;
  logic [NREG-1:0][7:0] live;
  logic [NREG-1:0][7:0] shadow_q;
  logic                 sec_pulse;
  logic                 day_adv;
  logic [CW-1:0]        pre_cnt;

  always_comb begin
    wr_sel = '0;
    if (reg_wr_i && (int'(reg_addr_i) < NREG)) wr_sel[reg_addr_i] = 1'b1;
  end
  assign wdata_m = reg_wdata_i & field_mask(reg_addr_i);

  rtc_prescaler #(.DIV(DIV)) i_prescaler (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .run_i   (!live[ADR_SEC][7]),
    .clr_i   (wr_sel[ADR_SEC]),
    .pulse_o (sec_pulse),
    .cnt_o   (pre_cnt)
  );

  rtc_clock_chain i_clock_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (sec_pulse),
    .wr_i    (wr_sel[2:0]),
    .wdata_i (wdata_m),
    .sec_o   (live[ADR_SEC]),
    .min_o   (live[ADR_MIN]),
    .hour_o  (live[ADR_HOUR]),
    .day_o   (day_adv)
  );

  rtc_calendar_chain i_calendar_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .day_i   (day_adv),
    .wr_i    (wr_sel[6:3]),
    .wdata_i (wdata_m),
    .date_o  (live[ADR_DATE]),
    .month_o (live[ADR_MONTH]),
    .dow_o   (live[ADR_DOW]),
    .year_o  (live[ADR_YEAR])
  );

  // holding bank: one byte per field, reset to the live reset values
  for (genvar g = 0; g < NREG; g++) begin : g_hold
    localparam logic [7:0] RST = (g == 3 || g == 4 || g == 5) ? 8'h01 : 8'h00;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         shadow_q[g] <= RST;
      else if (rd_latch_i) shadow_q[g] <= live[g];
    end
  end

  always_comb begin
    reg_rdata_o = 8'h00;
    if (int'(reg_addr_i) < NREG) reg_rdata_o = shadow_q[reg_addr_i];
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk #(
  parameter int NB = 56,
  parameter int CW = 15
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          rd_latch_i,
  input logic          reg_wr_i,
  input logic [2:0]    reg_addr_i,
  input logic [7:0]    reg_rdata_o,
  input logic          sec_pulse_i,
  input logic [CW-1:0] pre_cnt_i,
  input logic [NB-1:0] live_i,
  input logic [NB-1:0] shadow_i
);
  a_r1_pulse_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_i |-> tick_i);

  a_r2_sec_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_i && live_i[6:0] == 7'h59 && !reg_wr_i) |=> live_i[6:0] == 7'h00);

  a_r7_halt_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_i[7] && !reg_wr_i) |=> $stable(live_i));

  a_r8_sec_write_clears_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && reg_addr_i == 3'd0) |=> pre_cnt_i == '0);

  a_r9_latch_copies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_latch_i |=> shadow_i == $past(live_i));

  a_r9_bank_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_latch_i |=> $stable(shadow_i));

  a_r10_hour_bit6_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd2) |-> reg_rdata_o[6] == 1'b0);

  a_r10_dow_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd5) |-> reg_rdata_o[7:3] == 5'b0);

  a_r10_addr7_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 3'd7) |-> reg_rdata_o == 8'h00);
endmodule

bind rtc_bcd_core rtc_bcd_core_chk #(.NB(rtc_pkg::NREG * 8), .CW(CW)) i_rtc_bcd_core_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick_i      (tick_i),
  .rd_latch_i  (rd_latch_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .sec_pulse_i (sec_pulse),
  .pre_cnt_i   (pre_cnt),
  .live_i      (live),
  .shadow_i    (shadow_q)
);

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;
  localparam int BDIV = 4;
  localparam int WD   = 150000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick = 1'b0;
  logic       rd_latch = 1'b0;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [7:0] rb [8];

  // reference time
  int ms, mm, mh, m12, mpm, md, mmo, mdw, my;

  always #10 clk = ~clk;

  rtc_bcd_core #(.DIV(BDIV)) i_rtc_bcd_core (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .rd_latch_i  (rd_latch),
    .reg_wr_i    (reg_wr),
    .reg_addr_i  (reg_addr),
    .reg_wdata_i (reg_wdata),
    .reg_rdata_o (reg_rdata)
  );

  function automatic logic [7:0] bcd(int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic int mdays(int mo, int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  function automatic logic [7:0] exp_byte(int a);
    case (a)
      0: return bcd(ms);
      1: return bcd(mm);
      2: return m12 ? (8'h80 | (mpm ? 8'h20 : 8'h00) | bcd(mh)) : bcd(mh);
      3: return bcd(md);
      4: return bcd(mmo);
      5: return 8'(mdw);
      6: return bcd(my);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string req_of(int a);
    case (a)
      0, 1:    return "R2";
      2:       return m12 ? "R4" : "R3";
      5:       return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic model_day();
    mdw = (mdw == 7) ? 1 : mdw + 1;
    if (md == mdays(mmo, my)) begin
      md = 1;
      if (mmo == 12) begin mmo = 1; my = (my + 1) % 100; end
      else mmo++;
    end else md++;
  endtask

  task automatic model_sec();
    ms++;
    if (ms < 60) return;
    ms = 0; mm++;
    if (mm < 60) return;
    mm = 0;
    if (m12 != 0) begin
      if (mh == 11) begin
        mh = 12; mpm = 1 - mpm;
        if (mpm == 0) model_day();
      end else if (mh == 12) mh = 1;
      else mh++;
    end else begin
      mh++;
      if (mh == 24) begin mh = 0; model_day(); end
    end
  endtask

  task automatic chk(string rq, string what, logic [7:0] got, logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %02h exp %02h", rq, what, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic ticks(int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic read_regs(bit latch);
    if (latch) begin
      @(negedge clk); rd_latch = 1'b1;
      @(negedge clk); rd_latch = 1'b0;
    end
    for (int a = 0; a < 8; a++) begin
      reg_addr = 3'(a);
      #1;
      rb[a] = reg_rdata;
    end
  endtask

  task automatic check_model(string what);
    read_regs(1'b1);
    for (int a = 0; a < 7; a++) chk(req_of(a), what, rb[a], exp_byte(a));
  endtask

  task automatic load_model();
    wr(0, bcd(ms));
    for (int a = 1; a < 7; a++) wr(a, exp_byte(a));
  endtask

  task automatic corner(string what, int s, int m, int h, int t12, int pm,
                        int d, int mo, int dw, int y, int k);
    ms = s; mm = m; mh = h; m12 = t12; mpm = pm; md = d; mmo = mo; mdw = dw; my = y;
    load_model();
    ticks(BDIV * k);
    for (int i = 0; i < k; i++) model_sec();
    check_model(what);
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp finish");
      report();
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R11 reset state
    read_regs(1'b1);
    chk("R11", "reset sec",   rb[0], 8'h00);
    chk("R11", "reset min",   rb[1], 8'h00);
    chk("R11", "reset hour",  rb[2], 8'h00);
    chk("R11", "reset date",  rb[3], 8'h01);
    chk("R11", "reset month", rb[4], 8'h01);
    chk("R11", "reset dow",   rb[5], 8'h01);
    chk("R11", "reset year",  rb[6], 8'h00);

    // R1 gating and rate
    ms = 0; mm = 10; mh = 9; m12 = 0; mpm = 0; md = 5; mmo = 3; mdw = 2; my = 21;
    load_model();
    repeat (20) @(negedge clk);
    read_regs(1'b1);
    chk("R1", "idle no ticks", rb[0], 8'h00);
    ticks(BDIV * 3 - 1);
    read_regs(1'b1);
    chk("R1", "one tick short", rb[0], 8'h02);
    ticks(1);
    read_regs(1'b1);
    chk("R1", "three seconds", rb[0], 8'h03);

    // R8 divider clear on seconds write
    ticks(2);
    wr(0, 8'h10);
    ticks(BDIV - 1);
    read_regs(1'b1);
    chk("R8", "no advance after clear", rb[0], 8'h10);
    ticks(1);
    read_regs(1'b1);
    chk("R8", "advance at full period", rb[0], 8'h11);

    // R7 halt
    wr(0, 8'hB0);
    ticks(BDIV * 5);
    read_regs(1'b1);
    chk("R7", "halted sec", rb[0], 8'hB0);
    chk("R7", "halted min", rb[1], 8'h10);
    wr(0, 8'h30);
    ticks(BDIV * 2);
    read_regs(1'b1);
    chk("R7", "resumed sec", rb[0], 8'h32);

    // R9 snapshot holds across rollover
    ms = 59; mm = 59; mh = 12; m12 = 0; mpm = 0; md = 9; mmo = 9; mdw = 3; my = 30;
    load_model();
    read_regs(1'b1);
    ticks(BDIV);
    read_regs(1'b0);
    chk("R9", "held sec",  rb[0], 8'h59);
    chk("R9", "held min",  rb[1], 8'h59);
    chk("R9", "held hour", rb[2], 8'h12);
    model_sec();
    check_model("R9 relatch");

    // R10 unused bits
    wr(1, 8'hFF); wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'hFF); wr(5, 8'hFF);
    read_regs(1'b1);
    chk("R10", "min mask",   rb[1], 8'h7F);
    chk("R10", "hour mask",  rb[2], 8'hBF);
    chk("R10", "date mask",  rb[3], 8'h3F);
    chk("R10", "month mask", rb[4], 8'h1F);
    chk("R10", "dow mask",   rb[5], 8'h07);
    chk("R10", "addr 7",     rb[7], 8'h00);

    // directed carries
    corner("R3 R5 R6 year end",      59, 59, 23, 0, 0, 31, 12, 7, 99, 1);
    corner("R3 tens bit 19->20",     59, 59, 19, 0, 0, 10,  6, 4, 12, 1);
    corner("R4 11AM->12PM",          59, 59, 11, 1, 0, 14,  7, 1, 40, 1);
    corner("R4 11PM->12AM",          59, 59, 11, 1, 1, 28,  2, 5, 24, 1);
    corner("R4 12PM->1PM",           58, 59, 12, 1, 1,  3,  8, 6, 50, 3);
    corner("R5 common feb",          59, 59, 23, 0, 0, 28,  2, 2, 23, 1);
    corner("R5 leap feb 29",         59, 59, 23, 0, 0, 29,  2, 2, 96, 1);
    corner("R5 30 day month",        59, 59, 23, 0, 0, 30,  4, 6, 10, 2);

    // random near-boundary times
    for (int i = 0; i < 40; i++) begin
      int t12, h, mo, y;
      t12 = int'($urandom % 2);
      if (t12 != 0) h = ($urandom % 2 != 0) ? 11 : 1 + int'($urandom % 12);
      else          h = ($urandom % 2 != 0) ? 23 : int'($urandom % 24);
      mo = 1 + int'($urandom % 12);
      y  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
      corner("random", 50 + int'($urandom % 10),
             ($urandom % 2 != 0) ? 59 : int'($urandom % 60), h, t12,
             int'($urandom % 2), mdays(mo, y) - int'($urandom % 2), mo,
             1 + int'($urandom % 7), y, 1 + int'($urandom % 12));
    end

    finished = 1'b1;
    report();
  end
endmodule